// File: doc/BRIEF.md
# Serial Receiver with Flag-Tagged Character Queue

This block receives asynchronous serial characters and queues them for a host. The serial line is sampled at sixteen times the bit rate, using a one-cycle sample enable that a separate baud generator supplies. Each character is 5 to 8 data bits, sent least significant bit first, with optional even or odd parity and a stop bit. When the stop sample is complete, the character goes into an eight-entry queue. The queue entry also holds three error flags for that character: parity error, framing error and line break.

The host reads characters one at a time with a read strobe. An 8-bit status word is available at all times. Its upper three bits are the error flags of the character that the next read returns. Its lower five bits are live indications: overrun, line break in progress, sticky framing error, queue full and data ready. When the queue is full, one more character can wait in a holding register. An overrun is declared only when a further character completes while that holding register is still occupied.

Line-condition monitoring runs even when the receiver is disabled. This covers framing-error detection and break detection. A disabled receiver only stops characters from entering the queue.

Top module: `serial_rx_flagged`

## Requirements
- R1: A low line seen at a sample tick starts a start-bit check. If the line is high again at the mid-bit sample eight ticks later, the start is discarded, nothing is queued, and the receiver goes back to idle.
- R2: `char_len` selects 5 (0), 6 (1), 7 (2) or 8 (3) data bits. Bits arrive least significant first. Each bit is sampled sixteen ticks after the previous one. Unused upper bits of a queued character read as zero.
- R3: With `parity_en` high, one parity bit follows the data bits. `parity_odd` = 0 selects even parity and 1 selects odd parity. A mismatch sets the character's parity flag, which is status bit 5.
- R4: A stop bit sampled low at its middle sets the character's framing flag, which is status bit 6. It also sets the sticky status bit 2, which stays set until `err_clear`.
- R5: The queue holds up to 8 characters and returns them in arrival order. Status bit 0 is high when the queue is not empty. Status bit 1 is high when the queue holds 8 characters.
- R6: Status bits 7:5 are the break, framing and parity flags of the character the next read returns. They are zero while the queue is empty. After reset the status word and `rx_data` are zero.
- R7: A ninth character that arrives while the queue is full waits without raising overrun. It enters the queue in the same cycle that a read frees a place.
- R8: If another character completes while the queue is full and a character is already waiting, status bit 4 (overrun) is set. The newest character replaces the waiting one.
- R9: Overrun stays set through reads. Only `err_clear` clears it.
- R10: A character whose data bits, parity bit and stop bit are all low is queued once, as a zero with only the break flag set. Status bit 3 stays high, and no new start is accepted, until the line is seen high. A break that begins in the middle of a character first yields that character with its framing flag set, and then the break entry.
- R11: While `rx_enable` is low, no character enters the queue. Framing detection (status bit 2) and break detection (status bit 3) still operate.
- R12: A read strobe while the queue is empty leaves `rx_data` and the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_enable | input | 1 | Allows received characters into the queue |
| char_len | input | 2 | Data bits per character minus five |
| parity_en | input | 1 | A parity bit follows the data bits |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Pops one character into rx_data |
| err_clear | input | 1 | Clears overrun and the sticky framing bit |
| rx_data | output | 8 | Last character read from the queue |
| rx_status | output | 8 | {brk, fe, pe of next char, overrun, break active, framing seen, full, ready} |

## Verification
The hardest condition to reach is a break that starts in the middle of a character. The line has to fall during the data bits and stay low for longer than a whole further frame. Only then does one framing-error character appear, followed by exactly one break entry, with the break indication held until the line returns high. The bench builds this case bit by bit, inspects the status while the line is still low, and after release checks that nothing beyond the two entries was queued. Overrun likewise needs nine waiting characters plus one more before any read, so a directed burst of ten characters is sent. The random traffic also fills the queue whenever reads are skipped.

// File: rtl/srx_pkg.sv
// Package for the serial receiver: queue entry layout and receiver states.
// Assumes characters are at most eight data bits wide.
package srx_pkg;

    localparam int SRX_DATA_W = 8;

    // One queued character with its own error flags
    typedef struct packed {
        logic                  brk;
        logic                  fe;
        logic                  pe;
        logic [SRX_DATA_W-1:0] data;
    } srx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_MARK
    } srx_state_t;

endpackage

// File: rtl/srx_sync.sv
// Multi-stage synchronizer for the asynchronous serial input.
// Assumes STAGES >= 2. Resets to the idle (high) line level.
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage captures the raw line
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= din;
            end
        end else begin : g_next
            // Later stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/srx_framer.sv
// Oversampling character framer. It finds the start bit, samples every
// bit at mid-bit, checks parity and stop, and recognises line break.
// Assumes sample_tick pulses at OVS times the bit rate and rxd_s is
// already synchronous. Emits one ch_valid pulse for each completed
// character, regardless of whether the receiver is enabled.
module srx_framer import srx_pkg::*; #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd_s,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       ch_valid,
    output srx_entry_t ch_entry,
    output logic       brk_line
);

    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID_START = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] MID_BIT   = CNT_W'(OVS - 1);

    srx_state_t            state;
    logic [CNT_W-1:0]      cnt;
    logic [2:0]            bit_idx;
    logic [SRX_DATA_W-1:0] shreg;
    logic                  par_bit;

    logic [SRX_DATA_W-1:0] data_al;
    logic                  ones_odd;
    logic                  is_brk;
    logic                  pe_raw;
    logic [2:0]            last_idx;

    // Align the received bits and classify the character at the stop sample
    always_comb begin
        data_al  = shreg >> (2'd3 - char_len);
        last_idx = 3'(char_len) + 3'd4;
        ones_odd = (^data_al) ^ par_bit;
        pe_raw   = par_en & (par_odd ? ~ones_odd : ones_odd);
        is_brk   = (data_al == '0) & ~rxd_s & (~par_en | ~par_bit);
    end

    // Receive state machine, advanced only on sample ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            ch_valid <= 1'b0;
            ch_entry <= '0;
            brk_line <= 1'b0;
        end else begin
            ch_valid <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd_s) begin
                            cnt   <= '0;
                            state <= ST_START;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID_START) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            shreg   <= '0;
                            par_bit <= 1'b0;
                            state   <= rxd_s ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_DATA: begin
                        if (cnt == MID_BIT) begin
                            cnt   <= '0;
                            shreg <= {rxd_s, shreg[SRX_DATA_W-1:1]};
                            if (bit_idx == last_idx) begin
                                state <= par_en ? ST_PAR : ST_STOP;
                            end else begin
                                bit_idx <= bit_idx + 3'd1;
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_PAR: begin
                        if (cnt == MID_BIT) begin
                            cnt     <= '0;
                            par_bit <= rxd_s;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_STOP: begin
                        if (cnt == MID_BIT) begin
                            cnt           <= '0;
                            ch_valid      <= 1'b1;
                            ch_entry.brk  <= is_brk;
                            ch_entry.fe   <= ~rxd_s & ~is_brk;
                            ch_entry.pe   <= pe_raw & ~is_brk;
                            ch_entry.data <= is_brk ? '0 : data_al;
                            if (is_brk) begin
                                brk_line <= 1'b1;
                                state    <= ST_MARK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_MARK: begin
                        if (rxd_s) begin
                            brk_line <= 1'b0;
                            state    <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_BREAK_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> ($onehot0({ch_entry.brk, ch_entry.fe}) &&
                      (!ch_entry.brk || (ch_entry.data == '0 && !ch_entry.pe)))); // R10

    AST_NO_CHAR_WHILE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MARK && $past(state) == ST_MARK) |-> !ch_valid); // R10

    AST_BRK_LINE_CLEARS_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_line && tick && rxd_s) |=> !brk_line); // R10

endmodule

// File: rtl/srx_fifo.sv
// Character queue with per-entry error flags. Push and pop may occur in
// the same cycle, also when full. Pop on empty is ignored. Assumes
// DEPTH is a power of two.
module srx_fifo import srx_pkg::*; #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  srx_entry_t push_entry,
    input  logic       pop,
    output srx_entry_t top_entry,
    output logic       empty,
    output logic       full
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] FULL_CNT = (PTR_W + 1)'(DEPTH);

    srx_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W:0]   count;
    logic             do_push;
    logic             do_pop;

    assign empty     = (count == '0);
    assign full      = (count == FULL_CNT);
    assign do_pop    = pop & ~empty;
    assign do_push   = push & (~full | do_pop);
    assign top_entry = mem[rd_ptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + (PTR_W + 1)'(1);
                2'b01:   count <= count - (PTR_W + 1)'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop); // R5

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R5

endmodule

// File: rtl/serial_rx_flagged.sv
// Top of the serial receiver. It links the synchronizer, the framer and
// the queue, and owns the overflow holding register, the overrun and
// framing-seen bits, and the read data register. Assumes a single clock
// and a sample_tick from an external baud generator.
module serial_rx_flagged import srx_pkg::*; #(
    parameter int DEPTH       = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_tick,
    input  logic                  rxd,
    input  logic                  rx_enable,
    input  logic [1:0]            char_len,
    input  logic                  parity_en,
    input  logic                  parity_odd,
    input  logic                  rd_strobe,
    input  logic                  err_clear,
    output logic [SRX_DATA_W-1:0] rx_data,
    output logic [7:0]            rx_status
);

    logic       rxd_s;
    logic       ch_valid;
    srx_entry_t ch_entry;
    logic       brk_line;

    srx_entry_t top_entry;
    logic       empty;
    logic       full;
    logic       pop;
    logic       space;
    logic       fifo_push;
    srx_entry_t fifo_in;

    srx_entry_t hold_q;
    logic       hold_vld;
    logic       overrun;
    logic       fe_seen;
    logic       accept;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rxd_s)
    );

    srx_framer #(.OVS(OVS)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .rxd_s    (rxd_s),
        .char_len (char_len),
        .par_en   (parity_en),
        .par_odd  (parity_odd),
        .ch_valid (ch_valid),
        .ch_entry (ch_entry),
        .brk_line (brk_line)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (fifo_push),
        .push_entry (fifo_in),
        .pop        (pop),
        .top_entry  (top_entry),
        .empty      (empty),
        .full       (full)
    );

    assign pop    = rd_strobe & ~empty;
    assign space  = ~full | pop;
    assign accept = ch_valid & rx_enable;

    // Queue input: a waiting character goes first, otherwise a fresh one
    always_comb begin
        fifo_push = 1'b0;
        fifo_in   = hold_q;
        if (hold_vld) begin
            fifo_push = space;
        end else if (accept && space) begin
            fifo_push = 1'b1;
            fifo_in   = ch_entry;
        end
    end

    // Holding register for the character that arrives while the queue is full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            hold_vld <= 1'b0;
        end else if (accept && (hold_vld || !space)) begin
            hold_q   <= ch_entry;
            hold_vld <= 1'b1;
        end else if (hold_vld && space) begin
            hold_vld <= 1'b0;
        end
    end

    // Sticky error bits; a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
            fe_seen <= 1'b0;
        end else begin
            if (accept && hold_vld && !space) overrun <= 1'b1;
            else if (err_clear)               overrun <= 1'b0;
            if (ch_valid && ch_entry.fe)      fe_seen <= 1'b1;
            else if (err_clear)               fe_seen <= 1'b0;
        end
    end

    // Read data register, updated only by a successful pop
    always_ff @(posedge clk) begin
        if (!rst_n)   rx_data <= '0;
        else if (pop) rx_data <= top_entry.data;
    end

    assign rx_status = {top_entry.brk & ~empty, top_entry.fe & ~empty,
                        top_entry.pe & ~empty, overrun, brk_line, fe_seen,
                        full, ~empty};

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !err_clear) |=> overrun); // R9

    AST_OVERRUN_NEEDS_WAITER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(hold_vld) && $past(full))); // R8

    AST_EMPTY_READ_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && empty) |=> $stable(rx_data)); // R12

    AST_DISABLED_NO_NEW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !hold_vld) |-> !fifo_push); // R11

endmodule

// File: tb/tb_serial_rx_flagged.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared with a reference queue model kept in the bench.
module tb_serial_rx_flagged;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick;
    logic       rxd = 1'b1;
    logic       rx_enable = 1'b1;
    logic [1:0] char_len = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       err_clear = 1'b0;
    logic [7:0] rx_data;
    logic [7:0] rx_status;

    int n_checks = 0;
    int n_fail   = 0;
    int tdiv     = 0;

    // Reference model: entries are {brk, fe, pe, data}
    logic [10:0] exp_q[$];
    logic [10:0] m_hold = '0;
    logic        m_hold_vld = 1'b0;
    logic        m_ovr = 1'b0;
    logic        m_fe = 1'b0;

    serial_rx_flagged dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .rxd         (rxd),
        .rx_enable   (rx_enable),
        .char_len    (char_len),
        .parity_en   (parity_en),
        .parity_odd  (parity_odd),
        .rd_strobe   (rd_strobe),
        .err_clear   (err_clear),
        .rx_data     (rx_data),
        .rx_status   (rx_status)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    assign sample_tick = (tdiv == 0);

    function automatic logic [7:0] mask_len(logic [7:0] d, logic [1:0] len);
        return d & (8'hFF >> (2'd3 - len));
    endfunction

    function automatic logic par_bit_of(logic [7:0] m, logic podd, logic bad);
        return (^m) ^ podd ^ bad;
    endfunction

    function automatic logic [10:0] expect_entry(logic [7:0] m, logic pen,
                                                 logic pbit, logic bad, logic stop);
        logic brk;
        logic fe;
        logic pe;
        brk = (m == 8'h00) && !stop && (!pen || !pbit);
        fe  = !stop && !brk;
        pe  = pen && bad && !brk;
        return {brk, fe, pe, (brk ? 8'h00 : m)};
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_push(logic [10:0] e);
        if (exp_q.size() < 8) begin
            exp_q.push_back(e);
        end else if (!m_hold_vld) begin
            m_hold     = e;
            m_hold_vld = 1'b1;
        end else begin
            m_hold = e;
            m_ovr  = 1'b1;
        end
    endtask

    task automatic drive_bit(logic b);
        rxd = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // One frame plus one idle bit. A low stop bit is held low for three
    // quarters of a bit, so a new start picked up there is discarded.
    task automatic send(logic [7:0] d, logic bad, logic stop);
        logic [7:0] m;
        logic       pbit;
        m    = mask_len(d, char_len);
        pbit = parity_en ? par_bit_of(m, parity_odd, bad) : 1'b0;
        drive_bit(1'b0);
        for (int i = 0; i <= int'(char_len) + 4; i++) drive_bit(m[i]);
        if (parity_en) drive_bit(pbit);
        if (stop) begin
            drive_bit(1'b1);
        end else begin
            rxd = 1'b0;
            repeat (BIT_CLKS * 3 / 4) @(negedge clk);
            rxd = 1'b1;
            repeat (BIT_CLKS / 4) @(negedge clk);
        end
        drive_bit(1'b1);
        begin
            logic [10:0] e;
            e = expect_entry(m, parity_en, pbit, bad, stop);
            if (e[9]) m_fe = 1'b1;
            if (rx_enable) model_push(e);
        end
    endtask

    task automatic check_live(string tag);
        check(tag, rx_status[4:0],
              {27'd0, m_ovr, 1'b0, m_fe, exp_q.size() == 8, exp_q.size() != 0},
              "live status");
    endtask

    task automatic read_check(string tag);
        logic [10:0] e;
        if (exp_q.size() == 0) begin
            check(tag, rx_status[0], 0, "ready on empty");
            return;
        end
        e = exp_q.pop_front();
        check(tag, rx_status[7:5], e[10:8], "next-char flags");
        check(tag, rx_status[0], 1, "ready");
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check(tag, rx_data, e[7:0], "data");
        if (m_hold_vld) begin
            exp_q.push_back(m_hold);
            m_hold_vld = 1'b0;
        end
    endtask

    task automatic read_all(string tag);
        while (exp_q.size() != 0) read_check(tag);
    endtask

    task automatic pulse_clear();
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        m_ovr = 1'b0;
        m_fe  = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset state
        check("R6", rx_status, 0, "status after reset");
        check("R6", rx_data, 0, "data after reset");

        // R1: a low pulse shorter than half a bit is a false start
        rxd = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check("R1", rx_status, 0, "status after false start");

        // R2: character lengths, least significant bit first
        char_len = 2'd0;
        send(8'hF5, 1'b0, 1'b1);
        read_check("R2");
        char_len = 2'd2;
        send(8'h5A, 1'b0, 1'b1);
        read_check("R2");
        char_len = 2'd3;
        send(8'hA5, 1'b0, 1'b1);
        read_check("R2");

        // R3: even and odd parity, good and bad
        parity_en = 1'b1;
        parity_odd = 1'b0;
        send(8'h37, 1'b0, 1'b1);
        send(8'h37, 1'b1, 1'b1);
        parity_odd = 1'b1;
        send(8'h80, 1'b0, 1'b1);
        send(8'h80, 1'b1, 1'b1);
        read_all("R3");
        parity_en = 1'b0;
        parity_odd = 1'b0;

        // R4: framing error, per character and sticky
        send(8'h3C, 1'b0, 1'b0);
        check("R4", rx_status[2], 1, "sticky framing bit");
        read_check("R4");
        check("R4", rx_status[2], 1, "sticky framing after read");
        pulse_clear();
        check("R4", rx_status[2], 0, "framing bit cleared");

        // R5 / R7: fill the queue, a ninth character waits without overrun
        for (int i = 0; i < 8; i++) send(8'(8'h11 * i + 8'h01), 1'b0, 1'b1);
        check("R5", rx_status[1], 1, "full after eight");
        send(8'hC3, 1'b0, 1'b1);
        check("R7", rx_status[4], 0, "no overrun for ninth");
        read_check("R5");
        check("R7", rx_status[1], 1, "waiting char moved in on read");
        read_all("R5");
        check("R5", rx_status[1:0], 0, "empty after draining");

        // R8 / R9: tenth character overruns and replaces the waiting one
        for (int i = 0; i < 10; i++) send(8'(8'h20 + i), 1'b0, 1'b1);
        check("R8", rx_status[4], 1, "overrun set");
        for (int i = 0; i < 4; i++) read_check("R8");
        check("R9", rx_status[4], 1, "overrun held through reads");
        read_all("R8");
        check("R9", rx_status[4], 1, "overrun held when empty");
        pulse_clear();
        check("R9", rx_status[4], 0, "overrun cleared");

        // R10: break starting inside a character
        drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b0);
        drive_bit(1'b1);
        repeat (26) drive_bit(1'b0);
        check("R10", rx_status[3], 1, "break active while line low");
        model_push(11'b010_0000_0101);
        model_push(11'b100_0000_0000);
        m_fe = 1'b1;
        check("R10", rx_status[0], 1, "entries queued during break");
        drive_bit(1'b1);
        drive_bit(1'b1);
        check("R10", rx_status[3], 0, "break released on mark");
        read_check("R10");
        read_check("R10");
        check("R10", rx_status[0], 0, "only one break entry");
        pulse_clear();
        send(8'h69, 1'b0, 1'b1);
        read_check("R10");

        // R11: disabled receiver queues nothing but still sees framing
        rx_enable = 1'b0;
        send(8'h42, 1'b0, 1'b1);
        check("R11", rx_status[0], 0, "nothing queued while disabled");
        send(8'h42, 1'b0, 1'b0);
        check("R11", rx_status[2], 1, "framing seen while disabled");
        check("R11", rx_status[0], 0, "still empty");
        pulse_clear();
        rx_enable = 1'b1;

        // R12: read of an empty queue
        begin
            logic [7:0] d0;
            logic [7:0] s0;
            d0 = rx_data;
            s0 = rx_status;
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
            @(negedge clk);
            check("R12", rx_data, d0, "data after empty read");
            check("R12", rx_status, s0, "status after empty read");
        end

        // Random traffic across lengths, parity and errors (R2 R3 R4 R5 R8)
        for (int n = 0; n < 50; n++) begin
            char_len   = 2'($urandom % 4);
            parity_en  = 1'($urandom % 2);
            parity_odd = 1'($urandom % 2);
            send(8'($urandom), ($urandom % 4) == 0, ($urandom % 5) != 0);
            check_live("R5");
            if (($urandom % 3) == 0) read_all("R3");
        end
        read_all("R2");
        check_live("R4");
        pulse_clear();
        check_live("R9");

        finish_run();
    end

endmodule